// File: doc/BRIEF.md
# Partial-Address Cache Miss Filter

This block predicts, before a cache lookup finishes, whether the access will miss. It keeps a bit array indexed by the low `P_W` bits of the line address. These bits start just above the byte offset, so they cover the set index and a few tag bits. A lookup whose bit is clear is a guaranteed miss, and the pipeline can start the next-level access early. A lookup whose bit is set may hit. A cache fill sets the bit for the incoming line.

To avoid false "miss" answers, a bit is never cleared while some resident line still maps to it. The block keeps a shadow store with one partial address and one valid flag per cache set and way. On an eviction, the victim's slot is invalidated and its partial address is latched. In the following cycle, the partial address is compared in parallel against every still-valid shadow entry. The bit is cleared at the end of that cycle only if nothing matched and no fill in the same cycle targets the same bit.

Evictions are named by set and way. The set of a fill is taken from the low `SET_W` bits of its line address. With the defaults, the array has 512 bits (`P_W`=9) for a cache of 16 sets of 2 ways. `P_W` of 11, 13 or 15 gives the 2048, 8192 or 32768 bit arrays.

Top module: `miss_filter`

## Requirements
- R1: After reset, every lookup reports a guaranteed miss (`lk_may_hit_o`=0).
- R2: The lookup bit is chosen by `lk_addr_i[P_W-1:0]` only. Line addresses that agree in those bits give the same answer, and an address differing in them reads its own bit.
- R3: A fill sets the bit for `fill_addr_i[P_W-1:0]`. The change is visible on the lookup port from the first cycle after the fill edge.
- R4: An eviction whose victim shares its partial address with no other valid slot clears that bit. The clear occurs on the second edge after the eviction is presented. Until then, a lookup of that bit reports may-hit, and other bits are untouched.
- R5: An eviction whose victim shares its partial address with another valid slot leaves the bit set.
- R6: When a fill sets the same bit that a pending eviction would clear in the same cycle, the bit ends set.
- R7: When two slots holding the same partial address are evicted on consecutive cycles, the bit stays set after the first clear decision and is cleared by the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_addr_i | input | LINE_W | Line address being looked up |
| lk_may_hit_o | output | 1 | 1: may hit, 0: guaranteed miss |
| fill_i | input | 1 | A line is filled this cycle |
| fill_addr_i | input | LINE_W | Line address of the filled line; low SET_W bits give its set |
| fill_way_i | input | WAY_W | Way receiving the fill |
| evict_i | input | 1 | A line is evicted this cycle |
| evict_set_i | input | SET_W | Set of the evicted line |
| evict_way_i | input | WAY_W | Way of the evicted line |

## Verification
The hardest case to reach is a clear decision that races with other state changes. One race is a fill landing on the victim's bit in the very cycle the collision result is applied. The other is a second eviction of a colliding line arriving while the first one is still pending. The bench reaches both by driving the eviction on one negative edge and the fill or second eviction on the next. It then samples the lookup port between the two following edges, and again after them, to see both the kept and the cleared states.

// File: rtl/mf_pkg.sv
package mf_pkg;
  localparam int unsigned MF_LINE_W = 16;
  localparam int unsigned MF_P_W    = 9;
  localparam int unsigned MF_SET_W  = 4;
  localparam int unsigned MF_WAYS   = 2;

  typedef enum logic [1:0] {
    OP_LOOK  = 2'd0,
    OP_FILL  = 2'd1,
    OP_EVICT = 2'd2
  } mf_op_e;
endpackage

// File: rtl/mf_bit_array.sv
module mf_bit_array #(
  parameter int unsigned P_W = 9,
  localparam int unsigned NBITS = 1 << P_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic [P_W-1:0] set_idx_i,
  input  logic           clr_i,
  input  logic [P_W-1:0] clr_idx_i,
  input  logic [P_W-1:0] rd_idx_i,
  output logic           rd_o
);
  logic [NBITS-1:0] bits_q;

  // later assignment wins: set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else begin
      if (clr_i) bits_q[clr_idx_i] <= 1'b0;
      if (set_i) bits_q[set_idx_i] <= 1'b1;
    end
  end

  assign rd_o = bits_q[rd_idx_i];

  AST_FILL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> bits_q[$past(set_idx_i)]); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(set_i && set_idx_i == clr_idx_i) |=> !bits_q[$past(clr_idx_i)]); // R4
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i && clr_i && set_idx_i == clr_idx_i |=> bits_q[$past(clr_idx_i)]); // R6
endmodule

// File: rtl/mf_shadow.sv
module mf_shadow #(
  parameter int unsigned P_W   = 9,
  parameter int unsigned SET_W = 4,
  parameter int unsigned WAYS  = 2,
  localparam int unsigned WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned NSLOT  = (1 << SET_W) * WAYS,
  localparam int unsigned SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic [P_W-1:0]   fill_part_i,
  input  logic             evict_i,
  input  logic [SET_W-1:0] evict_set_i,
  input  logic [WAY_W-1:0] evict_way_i,
  output logic [P_W-1:0]   victim_part_o,
  output logic             victim_vld_o,
  input  logic [P_W-1:0]   cmp_part_i,
  output logic             match_o
);
  logic [P_W-1:0]   part_q [NSLOT];
  logic [NSLOT-1:0] vld_q;
  logic [NSLOT-1:0] hit;
  logic [SLOT_W-1:0] fill_slot, ev_slot;

  assign fill_slot = SLOT_W'(fill_set_i) * SLOT_W'(WAYS) + SLOT_W'(fill_way_i);
  assign ev_slot   = SLOT_W'(evict_set_i) * SLOT_W'(WAYS) + SLOT_W'(evict_way_i);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic fill_here, evict_here;
    assign fill_here  = fill_i  && (fill_slot == SLOT_W'(s));
    assign evict_here = evict_i && (ev_slot   == SLOT_W'(s));

    // a fill into the slot being evicted keeps the new line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[s]  <= 1'b0;
        part_q[s] <= '0;
      end else if (fill_here) begin
        vld_q[s]  <= 1'b1;
        part_q[s] <= fill_part_i;
      end else if (evict_here) begin
        vld_q[s]  <= 1'b0;
      end
    end

    assign hit[s] = vld_q[s] && (part_q[s] == cmp_part_i);

    AST_EVICT_INVALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evict_here && !fill_here |=> !vld_q[s]); // R4
    AST_FILL_RECORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fill_here |=> vld_q[s] && part_q[s] == $past(fill_part_i)); // R5
  end

  assign victim_part_o = part_q[ev_slot];
  assign victim_vld_o  = vld_q[ev_slot];
  assign match_o       = |hit;
endmodule

// File: rtl/miss_filter.sv
module miss_filter #(
  parameter int unsigned LINE_W = mf_pkg::MF_LINE_W,
  parameter int unsigned P_W    = mf_pkg::MF_P_W,
  parameter int unsigned SET_W  = mf_pkg::MF_SET_W,
  parameter int unsigned WAYS   = mf_pkg::MF_WAYS,
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] lk_addr_i,
  output logic              lk_may_hit_o,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_addr_i,
  input  logic [WAY_W-1:0]  fill_way_i,
  input  logic              evict_i,
  input  logic [SET_W-1:0]  evict_set_i,
  input  logic [WAY_W-1:0]  evict_way_i
);
  logic [P_W-1:0] fill_part, vic_part, vic_q;
  logic           vic_vld, pend_q, match, clr;

  assign fill_part = fill_addr_i[P_W-1:0];

  mf_shadow #(.P_W(P_W), .SET_W(SET_W), .WAYS(WAYS)) u_shadow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_i       (fill_i),
    .fill_set_i   (fill_addr_i[SET_W-1:0]),
    .fill_way_i   (fill_way_i),
    .fill_part_i  (fill_part),
    .evict_i      (evict_i),
    .evict_set_i  (evict_set_i),
    .evict_way_i  (evict_way_i),
    .victim_part_o(vic_part),
    .victim_vld_o (vic_vld),
    .cmp_part_i   (vic_q),
    .match_o      (match)
  );

  // stage 1: latch victim; stage 2: search remaining residents, clear if alone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      vic_q  <= '0;
    end else begin
      pend_q <= evict_i && vic_vld;
      vic_q  <= vic_part;
    end
  end

  assign clr = pend_q && !match;

  mf_bit_array #(.P_W(P_W)) u_bits (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (fill_i),
    .set_idx_i(fill_part),
    .clr_i    (clr),
    .clr_idx_i(vic_q),
    .rd_idx_i (lk_addr_i[P_W-1:0]),
    .rd_o     (lk_may_hit_o)
  );

  AST_FILL_VISIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fill_i) && lk_addr_i[P_W-1:0] == $past(fill_part) |-> lk_may_hit_o); // R3
  AST_PENDING_SEES_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && lk_addr_i[P_W-1:0] == vic_q |-> lk_may_hit_o); // R4
  AST_COLLISION_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && match && lk_addr_i[P_W-1:0] == vic_q |=> $past(lk_may_hit_o)); // R5
endmodule

// File: tb/miss_filter_test.sv
module miss_filter_test;
  import mf_pkg::*;

  typedef struct packed {
    mf_op_e      op;
    logic [15:0] addr;
    logic        way;
    logic [3:0]  set;
    logic [15:0] chk;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{OP_LOOK,  16'h0000, 1'b0, 4'd0, 16'h0012, 1'b0, 4'd1}, // R1
    '{OP_FILL,  16'h0012, 1'b0, 4'd0, 16'h0012, 1'b1, 4'd3}, // R3
    '{OP_LOOK,  16'h0000, 1'b0, 4'd0, 16'h0212, 1'b1, 4'd2}, // R2 alias
    '{OP_LOOK,  16'h0000, 1'b0, 4'd0, 16'h0013, 1'b0, 4'd2}, // R2 other bit
    '{OP_FILL,  16'h0412, 1'b1, 4'd0, 16'h0412, 1'b1, 4'd3}, // R3
    '{OP_EVICT, 16'h0000, 1'b0, 4'd2, 16'h0012, 1'b1, 4'd5}, // R5 collision
    '{OP_EVICT, 16'h0000, 1'b1, 4'd2, 16'h0012, 1'b0, 4'd4}, // R4 last one
    '{OP_FILL,  16'h00A5, 1'b0, 4'd0, 16'h00A5, 1'b1, 4'd3}, // R3
    '{OP_FILL,  16'h01A5, 1'b1, 4'd0, 16'h01A5, 1'b1, 4'd3}, // R3
    '{OP_EVICT, 16'h0000, 1'b0, 4'd5, 16'h00A5, 1'b0, 4'd4}, // R4
    '{OP_LOOK,  16'h0000, 1'b0, 4'd0, 16'h01A5, 1'b1, 4'd4}  // R4 neighbour kept
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lk_addr_i = '0;
  logic        lk_may_hit_o;
  logic        fill_i = 1'b0;
  logic [15:0] fill_addr_i = '0;
  logic        fill_way_i = 1'b0;
  logic        evict_i = 1'b0;
  logic [3:0]  evict_set_i = '0;
  logic        evict_way_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  miss_filter uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_addr_i(lk_addr_i), .lk_may_hit_o(lk_may_hit_o),
    .fill_i(fill_i), .fill_addr_i(fill_addr_i), .fill_way_i(fill_way_i),
    .evict_i(evict_i), .evict_set_i(evict_set_i), .evict_way_i(evict_way_i)
  );

  task automatic check(input logic [15:0] a, input logic exp, input string req);
    lk_addr_i = a;
    #1;
    n_chk++;
    if (lk_may_hit_o !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h may_hit actual=%b expected=%b", req, a, lk_may_hit_o, exp);
    end
  endtask

  task automatic do_fill(input logic [15:0] a, input logic w);
    @(negedge clk_i);
    fill_i = 1'b1; fill_addr_i = a; fill_way_i = w;
    @(negedge clk_i);
    fill_i = 1'b0;
  endtask

  task automatic do_evict(input logic [3:0] s, input logic w);
    @(negedge clk_i);
    evict_i = 1'b1; evict_set_i = s; evict_way_i = w;
    @(negedge clk_i);
    evict_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_FILL:  do_fill(VECS[i].addr, VECS[i].way);
        OP_EVICT: do_evict(VECS[i].set, VECS[i].way);
        default:  ;
      endcase
      @(negedge clk_i);
      check(VECS[i].chk, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R4: lookup during the pending cycle still sees the bit
    do_fill(16'h0077, 1'b0);
    @(negedge clk_i);
    evict_i = 1'b1; evict_set_i = 4'd7; evict_way_i = 1'b0;
    @(negedge clk_i);
    evict_i = 1'b0;
    check(16'h0077, 1'b1, "R4 pending");
    @(negedge clk_i);
    check(16'h0077, 1'b0, "R4 cleared");

    // R6: fill lands on the bit in the clear-decision cycle
    do_fill(16'h0088, 1'b0);
    @(negedge clk_i);
    evict_i = 1'b1; evict_set_i = 4'd8; evict_way_i = 1'b0;
    @(negedge clk_i);
    evict_i = 1'b0;
    fill_i = 1'b1; fill_addr_i = 16'h0088; fill_way_i = 1'b1;
    @(negedge clk_i);
    fill_i = 1'b0;
    check(16'h0088, 1'b1, "R6 set wins");
    @(negedge clk_i);
    check(16'h0088, 1'b1, "R6 held");
    do_evict(4'd8, 1'b1);
    @(negedge clk_i);
    check(16'h0088, 1'b0, "R6 later clear");

    // R7: back-to-back evictions of two lines sharing one bit
    do_fill(16'h0099, 1'b0);
    do_fill(16'h0299, 1'b1);
    @(negedge clk_i);
    evict_i = 1'b1; evict_set_i = 4'd9; evict_way_i = 1'b0;
    @(negedge clk_i);
    evict_way_i = 1'b1;
    @(negedge clk_i);
    evict_i = 1'b0;
    check(16'h0099, 1'b1, "R7 first kept");
    @(negedge clk_i);
    check(16'h0099, 1'b0, "R7 second clears");

    // R1: reset wipes a filled bit
    do_fill(16'h0123, 1'b0);
    check(16'h0123, 1'b1, "R3 before reset");
    rst_ni = 1'b0;
    #1;
    check(16'h0123, 1'b0, "R1 after reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(16'h0012, 1'b0, "R1 after reset other");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule